// File: doc/BRIEF.md
# Region Priority and Access Permission Checker

This block takes the per-region hit bits produced by an address comparator elsewhere, together with each region's attribute bits, and decides whether one memory access is allowed. When regions overlap, the region with the highest index is the only one that counts, however permissive or restrictive it is. That region's attributes are then tested against the access. The tests for no-access, read-only, privileged-only and execute-never are independent of one another.

An access is presented for one cycle with `acc_valid`. The verdict appears on `access_fault` in the following cycle. The first faulting address is kept in a fault-address register with a valid flag. It stays there until `fault_clr` is pulsed. An access that hits no region uses a background rule: only a privileged access with `bg_enable` set is allowed.

Top module: `mpu_region_arbiter`

## Requirements
- R1: Bit i of every per-region vector belongs to region i. When several regions hit, only the attributes of the highest-indexed hit region are used, even if a lower-indexed region is more restrictive.
- R2: If the winning region has its no-access bit set, every access kind at both privilege levels faults.
- R3: If the winning region is read-only, reads are allowed and writes fault, whether the access is privileged or not.
- R4: An instruction fetch from a winning region marked execute-never faults. Reads and writes to that region are not affected by the execute-never bit.
- R5: If the winning region is privileged-only, every unprivileged access faults. A privileged access to a region that is both privileged-only and read-only still faults on a write.
- R6: An access that hits no region is allowed only when `acc_priv` is 1 and `bg_enable` is 1. In every other case it faults.
- R7: `access_fault` is high for exactly the cycle after a denied access that had `acc_valid` high. A cycle with `acc_valid` low never produces a fault.
- R8: On a fault while `fault_addr_valid` is 0, the access address is loaded into `fault_addr` and `fault_addr_valid` is set, both in the same cycle that `access_fault` rises. While the flag is set, later faults leave `fault_addr` unchanged.
- R9: A `fault_clr` pulse clears `fault_addr_valid` on the next edge. A fault arriving in the same cycle as the clear is captured as a new first fault.
- R10: `acc_kind` encodes 0 as read, 1 as write and 2 as instruction fetch. The value 3 is reserved, and an access with kind 3 always faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | ADDR_W | Address of the access |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 reserved |
| acc_priv | input | 1 | 1 for a privileged access |
| bg_enable | input | 1 | Enables the background rule for privileged accesses that hit no region |
| rgn_hit | input | NUM_REGIONS | Per-region address match |
| rgn_no_access | input | NUM_REGIONS | Per-region: deny every access |
| rgn_read_only | input | NUM_REGIONS | Per-region: deny writes |
| rgn_priv_only | input | NUM_REGIONS | Per-region: deny unprivileged accesses |
| rgn_exec_never | input | NUM_REGIONS | Per-region: deny instruction fetches |
| fault_clr | input | 1 | Releases the fault-address register |
| access_fault | output | 1 | Verdict for the previous cycle's access |
| fault_addr | output | ADDR_W | Address of the first captured fault |
| fault_addr_valid | output | 1 | `fault_addr` holds a fault that has not been cleared |

## Verification
The bench builds the block with eight regions and a 32-bit address. With eight regions, a broad permissive region and a narrow guard can be placed at low and high indices in both orders, and the top region seen by the checker's assertions can be driven directly. The full address width lets the bench use distinct, recognisable fault addresses. This shows which fault was kept and which later ones were rejected, including a fault that arrives in the same cycle as a clear.

// File: rtl/mpu_region_pkg.sv
package mpu_region_pkg;

    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_FETCH = 2'd2,
        KIND_RSVD  = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic no_access;
        logic read_only;
        logic priv_only;
        logic exec_never;
    } rgn_attr_t;

endpackage

// File: rtl/mpu_hit_prio.sv
// Highest-index-first priority over region hits, one-hot result.
module mpu_hit_prio #(
    parameter int NUM_REGIONS = 8
) (
    input  logic [NUM_REGIONS-1:0] hit,
    output logic [NUM_REGIONS-1:0] win,
    output logic                   any_hit
);
    // above[i] is set when some region with index greater than i hits
    logic [NUM_REGIONS-1:0] above;

    assign above[NUM_REGIONS-1] = 1'b0;

    generate
        for (genvar i = NUM_REGIONS - 2; i >= 0; i--) begin : g_chain
            assign above[i] = above[i+1] | hit[i+1];
        end
        for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_win
            assign win[i] = hit[i] & ~above[i];
        end
    endgenerate

    assign any_hit = |hit;
endmodule

// File: rtl/mpu_attr_select.sv
// AND-OR selection of the winning region's attribute bits.
module mpu_attr_select
    import mpu_region_pkg::*;
#(
    parameter int NUM_REGIONS = 8
) (
    input  logic [NUM_REGIONS-1:0] win,
    input  logic [NUM_REGIONS-1:0] no_access,
    input  logic [NUM_REGIONS-1:0] read_only,
    input  logic [NUM_REGIONS-1:0] priv_only,
    input  logic [NUM_REGIONS-1:0] exec_never,
    output rgn_attr_t              attr
);
    rgn_attr_t masked [NUM_REGIONS];

    generate
        for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_mask
            assign masked[i].no_access  = win[i] & no_access[i];
            assign masked[i].read_only  = win[i] & read_only[i];
            assign masked[i].priv_only  = win[i] & priv_only[i];
            assign masked[i].exec_never = win[i] & exec_never[i];
        end
    endgenerate

    always_comb begin
        attr = '0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            attr = attr | masked[i];
        end
    end
endmodule

// File: rtl/mpu_perm_eval.sv
// Independent permission axes applied to the selected attributes.
module mpu_perm_eval
    import mpu_region_pkg::*;
(
    input  logic       any_hit,
    input  rgn_attr_t  attr,
    input  logic [1:0] kind,
    input  logic       priv,
    input  logic       bg_enable,
    output logic       deny
);
    acc_kind_e kind_e;
    logic      deny_region;
    logic      deny_backgr;
    logic      deny_kind;

    assign kind_e = acc_kind_e'(kind);

    always_comb begin
        deny_region = 1'b0;
        if (attr.no_access) begin
            deny_region = 1'b1;
        end
        if (attr.priv_only && !priv) begin
            deny_region = 1'b1;
        end
        if (attr.read_only && kind_e == KIND_WRITE) begin
            deny_region = 1'b1;
        end
        if (attr.exec_never && kind_e == KIND_FETCH) begin
            deny_region = 1'b1;
        end
    end

    assign deny_backgr = !(priv && bg_enable);
    assign deny_kind   = (kind_e == KIND_RSVD);
    assign deny        = deny_kind | (any_hit ? deny_region : deny_backgr);
endmodule

// File: rtl/mpu_region_arbiter.sv
module mpu_region_arbiter
    import mpu_region_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int ADDR_W      = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   acc_valid,
    input  logic [ADDR_W-1:0]      acc_addr,
    input  logic [1:0]             acc_kind,
    input  logic                   acc_priv,
    input  logic                   bg_enable,
    input  logic [NUM_REGIONS-1:0] rgn_hit,
    input  logic [NUM_REGIONS-1:0] rgn_no_access,
    input  logic [NUM_REGIONS-1:0] rgn_read_only,
    input  logic [NUM_REGIONS-1:0] rgn_priv_only,
    input  logic [NUM_REGIONS-1:0] rgn_exec_never,
    input  logic                   fault_clr,
    output logic                   access_fault,
    output logic [ADDR_W-1:0]      fault_addr,
    output logic                   fault_addr_valid
);
    typedef struct packed {
        logic              fault;
        logic              cap_vld;
        logic [ADDR_W-1:0] cap_addr;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_REGIONS-1:0] win;
    logic                   any_hit;
    rgn_attr_t              win_attr;
    logic                   deny;
    logic                   new_fault;

    mpu_hit_prio #(.NUM_REGIONS(NUM_REGIONS)) u_prio (
        .hit     (rgn_hit),
        .win     (win),
        .any_hit (any_hit)
    );

    mpu_attr_select #(.NUM_REGIONS(NUM_REGIONS)) u_sel (
        .win        (win),
        .no_access  (rgn_no_access),
        .read_only  (rgn_read_only),
        .priv_only  (rgn_priv_only),
        .exec_never (rgn_exec_never),
        .attr       (win_attr)
    );

    mpu_perm_eval u_perm (
        .any_hit   (any_hit),
        .attr      (win_attr),
        .kind      (acc_kind),
        .priv      (acc_priv),
        .bg_enable (bg_enable),
        .deny      (deny)
    );

    assign new_fault = acc_valid & deny;

    always_comb begin
        st_d       = st_q;
        st_d.fault = new_fault;
        if (fault_clr) begin
            st_d.cap_vld = 1'b0;
        end
        if (new_fault && !st_d.cap_vld) begin
            st_d.cap_vld  = 1'b1;
            st_d.cap_addr = acc_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign access_fault     = st_q.fault;
    assign fault_addr       = st_q.cap_addr;
    assign fault_addr_valid = st_q.cap_vld;
endmodule

// File: rtl/mpu_region_arbiter_sva.sv
module mpu_region_arbiter_sva #(
    parameter int NUM_REGIONS = 8,
    parameter int ADDR_W      = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   acc_valid,
    input logic [1:0]             acc_kind,
    input logic                   acc_priv,
    input logic                   bg_enable,
    input logic [NUM_REGIONS-1:0] rgn_hit,
    input logic [NUM_REGIONS-1:0] rgn_no_access,
    input logic [NUM_REGIONS-1:0] rgn_read_only,
    input logic [NUM_REGIONS-1:0] rgn_priv_only,
    input logic [NUM_REGIONS-1:0] rgn_exec_never,
    input logic                   fault_clr,
    input logic                   access_fault,
    input logic [ADDR_W-1:0]      fault_addr,
    input logic                   fault_addr_valid
);
    localparam int TOP = NUM_REGIONS - 1;

    // top region fully open: lower regions cannot deny
    assert_top_open_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && rgn_hit[TOP] && !rgn_no_access[TOP] && !rgn_read_only[TOP]
        && !rgn_priv_only[TOP] && !rgn_exec_never[TOP] && acc_kind != 2'd3
        |=> !access_fault);

    assert_top_noaccess_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && rgn_hit[TOP] && rgn_no_access[TOP] |=> access_fault);

    assert_ro_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && rgn_hit[TOP] && rgn_read_only[TOP] && acc_kind == 2'd1
        |=> access_fault);

    assert_xn_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && rgn_hit[TOP] && rgn_exec_never[TOP] && acc_kind == 2'd2
        |=> access_fault);

    assert_unmatched_user_R6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && rgn_hit == '0 && !(acc_priv && bg_enable) |=> access_fault);

    assert_fault_needs_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !access_fault);

    assert_capture_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fault_addr_valid && !fault_clr |=> fault_addr_valid && $stable(fault_addr));

    assert_capture_with_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_addr_valid) |-> access_fault);

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_clr && !acc_valid |=> !fault_addr_valid);

    assert_rsvd_kind_R10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_kind == 2'd3 |=> access_fault);
endmodule

bind mpu_region_arbiter mpu_region_arbiter_sva #(
    .NUM_REGIONS (NUM_REGIONS),
    .ADDR_W      (ADDR_W)
) u_sva (
    .clk              (clk),
    .rst_n            (rst_n),
    .acc_valid        (acc_valid),
    .acc_kind         (acc_kind),
    .acc_priv         (acc_priv),
    .bg_enable        (bg_enable),
    .rgn_hit          (rgn_hit),
    .rgn_no_access    (rgn_no_access),
    .rgn_read_only    (rgn_read_only),
    .rgn_priv_only    (rgn_priv_only),
    .rgn_exec_never   (rgn_exec_never),
    .fault_clr        (fault_clr),
    .access_fault     (access_fault),
    .fault_addr       (fault_addr),
    .fault_addr_valid (fault_addr_valid)
);

// File: tb/tb_mpu_region_arbiter.sv
module tb_mpu_region_arbiter;
    localparam int N  = 8;
    localparam int AW = 32;
    localparam logic [1:0] RD = 2'd0, WR = 2'd1, FE = 2'd2, RS = 2'd3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic [1:0]    acc_kind = RD;
    logic          acc_priv = 1'b0;
    logic          bg_enable = 1'b0;
    logic [N-1:0]  hit = '0, noacc = '0, ro = '0, po = '0, xn = '0;
    logic          fault_clr = 1'b0;
    logic          access_fault;
    logic [AW-1:0] fault_addr;
    logic          fault_addr_valid;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    mpu_region_arbiter #(.NUM_REGIONS(N), .ADDR_W(AW)) dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .acc_valid        (acc_valid),
        .acc_addr         (acc_addr),
        .acc_kind         (acc_kind),
        .acc_priv         (acc_priv),
        .bg_enable        (bg_enable),
        .rgn_hit          (hit),
        .rgn_no_access    (noacc),
        .rgn_read_only    (ro),
        .rgn_priv_only    (po),
        .rgn_exec_never   (xn),
        .fault_clr        (fault_clr),
        .access_fault     (access_fault),
        .fault_addr       (fault_addr),
        .fault_addr_valid (fault_addr_valid)
    );

    task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wipe_regions();
        hit = '0; noacc = '0; ro = '0; po = '0; xn = '0;
    endtask

    // drive at a falling edge, verdict checked at the next falling edge
    task automatic access(input logic [AW-1:0] a, input logic [1:0] k,
                          input logic p, input logic exp, input string tag);
        acc_addr = a; acc_kind = k; acc_priv = p; acc_valid = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0;
        chk(tag, {31'd0, access_fault}, {31'd0, exp});
    endtask

    task automatic clear_capture();
        fault_clr = 1'b1;
        @(negedge clk);
        fault_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R7 reset fault", {31'd0, access_fault}, 32'd0);
        chk("R8 reset capture flag", {31'd0, fault_addr_valid}, 32'd0);
    endtask

    task automatic t_priority();
        wipe_regions();
        hit[0] = 1'b1; hit[1] = 1'b1; noacc[1] = 1'b1;
        access(32'h2000_0010, WR, 1'b1, 1'b1, "R2 guard above broad");
        access(32'h2000_0010, RD, 1'b0, 1'b1, "R2 guard read unpriv");
        wipe_regions();
        hit[0] = 1'b1; hit[1] = 1'b1; noacc[0] = 1'b1;
        access(32'h2000_0010, WR, 1'b1, 1'b0, "R1 guard below broad ignored");
        hit[7] = 1'b1; noacc[7] = 1'b1;
        access(32'h2000_0014, FE, 1'b1, 1'b1, "R1 top region decides");
        clear_capture();
    endtask

    task automatic t_read_only();
        wipe_regions();
        hit[3] = 1'b1; ro[3] = 1'b1;
        access(32'h100, RD, 1'b0, 1'b0, "R3 ro read unpriv");
        access(32'h104, RD, 1'b1, 1'b0, "R3 ro read priv");
        access(32'h108, WR, 1'b1, 1'b1, "R3 ro write priv");
        access(32'h10C, WR, 1'b0, 1'b1, "R3 ro write unpriv");
        clear_capture();
    endtask

    task automatic t_exec_never();
        wipe_regions();
        hit[5] = 1'b1; xn[5] = 1'b1;
        access(32'h200, FE, 1'b1, 1'b1, "R4 xn fetch");
        access(32'h204, WR, 1'b0, 1'b0, "R4 xn write");
        access(32'h208, RD, 1'b0, 1'b0, "R4 xn read");
        xn[5] = 1'b0;
        access(32'h20C, FE, 1'b0, 1'b0, "R4 fetch without xn");
        clear_capture();
    endtask

    task automatic t_priv_only();
        wipe_regions();
        hit[2] = 1'b1; po[2] = 1'b1;
        access(32'h300, RD, 1'b0, 1'b1, "R5 unpriv read");
        access(32'h304, WR, 1'b1, 1'b0, "R5 priv write");
        ro[2] = 1'b1;
        access(32'h308, WR, 1'b1, 1'b1, "R5 priv write ro");
        access(32'h30C, RD, 1'b1, 1'b0, "R5 priv read ro");
        clear_capture();
    endtask

    task automatic t_background();
        wipe_regions();
        bg_enable = 1'b1;
        access(32'h400, WR, 1'b1, 1'b0, "R6 priv bg on");
        access(32'h404, RD, 1'b0, 1'b1, "R6 unpriv bg on");
        bg_enable = 1'b0;
        access(32'h408, RD, 1'b1, 1'b1, "R6 priv bg off");
        clear_capture();
    endtask

    task automatic t_capture();
        wipe_regions();
        clear_capture();
        chk("R9 flag clear", {31'd0, fault_addr_valid}, 32'd0);
        hit[4] = 1'b1; noacc[4] = 1'b1;
        access(32'hDEAD_0001, RD, 1'b1, 1'b1, "R8 first fault");
        chk("R8 first addr", fault_addr, 32'hDEAD_0001);
        chk("R8 flag set", {31'd0, fault_addr_valid}, 32'd1);
        access(32'hBEEF_0002, WR, 1'b1, 1'b1, "R8 second fault");
        chk("R8 addr kept", fault_addr, 32'hDEAD_0001);
        clear_capture();
        chk("R9 cleared", {31'd0, fault_addr_valid}, 32'd0);
        // clear and fault in the same cycle
        fault_clr = 1'b1;
        access(32'hCAFE_0003, RD, 1'b0, 1'b1, "R9 fault with clear");
        fault_clr = 1'b0;
        chk("R9 same-cycle addr", fault_addr, 32'hCAFE_0003);
        chk("R9 same-cycle flag", {31'd0, fault_addr_valid}, 32'd1);
        clear_capture();
    endtask

    task automatic t_idle_and_kind();
        wipe_regions();
        hit[6] = 1'b1; noacc[6] = 1'b1;
        acc_addr = 32'h500; acc_valid = 1'b0;
        @(negedge clk);
        chk("R7 no valid no fault", {31'd0, access_fault}, 32'd0);
        chk("R7 no valid no capture", {31'd0, fault_addr_valid}, 32'd0);
        wipe_regions();
        hit[6] = 1'b1;
        access(32'h504, RS, 1'b1, 1'b1, "R10 reserved kind");
        access(32'h508, RD, 1'b1, 1'b0, "R10 read code 0 allowed");
        access(32'h50C, FE, 1'b1, 1'b0, "R10 fetch code 2 allowed");
        clear_capture();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_priority();
        t_read_only();
        t_exec_never();
        t_priv_only();
        t_background();
        t_capture();
        t_idle_and_kind();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL R7 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule